// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block supplies the word address for every beat of a four-beat burst inside a synchronous pipelined SRAM. On a load command it captures the external address and opens a burst. On each later advance command it steps the two least significant address bits in linear or interleaved order, and it keeps the upper bits fixed. A load issued while the chip is not selected closes any open burst. A low clock enable freezes the block completely.

Control is a two-state machine. `ST_IDLE` means no burst is open and `ST_BURST` means a burst is running. The decoded commands are LOAD, STOP, STEP and HOLD, and they drive these named transitions:
- OPEN: `ST_IDLE` to `ST_BURST` on LOAD.
- RELOAD: `ST_BURST` to `ST_BURST` on LOAD.
- STEP: `ST_BURST` to `ST_BURST` on STEP.
- CLOSE: `ST_BURST` or `ST_IDLE` to `ST_IDLE` on STOP.
- IGNORE: `ST_IDLE` to `ST_IDLE` on STEP.
- FREEZE: stay in the current state on HOLD.

The address and the burst flag are registered, so each result appears after the rising edge that sampled the command. The order pin is treated as static while a burst runs.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted, and right after it is released, `burst_act` is 0 and `cur_addr` is all zeros.
- R2: On a rising edge with `clk_en`=1, `adv_ld`=0 and `chip_sel`=1 (LOAD), the next `cur_addr` equals `ext_addr` and `burst_act` becomes 1.
- R3: With `order_ilv`=0, the STEP that produces beat k of a burst sets `cur_addr[1:0]` to (start + k) mod 4, where start is `ext_addr[1:0]` at the load.
- R4: With `order_ilv`=1, the STEP that produces beat k sets `cur_addr[1:0]` to start XOR k.
- R5: A STEP never changes `cur_addr[AW-1:2]`.
- R6: The STEP after the fourth beat brings the low bits back to start, and stepping then continues in the same order.
- R7: On a rising edge with `clk_en`=1, `adv_ld`=0 and `chip_sel`=0 (STOP), `burst_act` becomes 0 and `cur_addr` keeps its value.
- R8: An edge with `clk_en`=1 and `adv_ld`=1 while `burst_act`=0 leaves both `cur_addr` and `burst_act` unchanged.
- R9: An edge with `clk_en`=0 leaves both outputs unchanged, whatever the other inputs are.
- R10: A LOAD issued during a burst restarts the sequence at the new address, at beat 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Synchronous enable; when 0 the edge has no effect |
| adv_ld | input | 1 | 1 = advance the burst, 0 = load or deselect |
| chip_sel | input | 1 | 1 when the chip is selected |
| ext_addr | input | AW | External word address, used only on LOAD |
| order_ilv | input | 1 | 1 = interleaved order, 0 = linear order |
| cur_addr | output | AW | Current internal word address |
| burst_act | output | 1 | 1 while a burst is open |

## Verification
Every command changes the outputs exactly one rising edge after it is sampled. The bench drives inputs on the falling edge, lets a single rising edge pass, and compares both outputs with its reference model at the next falling edge. It therefore reads each result half a cycle after it becomes due and before the next command takes effect. Frozen and ignored commands are checked in the same way: the outputs one edge later must match the values held before the command.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } seq_state_e;

    typedef enum logic [1:0] {
        CMD_HOLD = 2'd0,
        CMD_LOAD = 2'd1,
        CMD_STOP = 2'd2,
        CMD_STEP = 2'd3
    } seq_cmd_e;

endpackage

// File: rtl/seq_cmd_decode.sv
module seq_cmd_decode
    import burst_seq_pkg::*;
(
    input  logic     clk_en,
    input  logic     adv_ld,
    input  logic     chip_sel,
    output seq_cmd_e cmd
);

    always_comb begin
        if (!clk_en) begin
            cmd = CMD_HOLD;
        end else if (adv_ld) begin
            cmd = CMD_STEP;
        end else if (chip_sel) begin
            cmd = CMD_LOAD;
        end else begin
            cmd = CMD_STOP;
        end
    end

endmodule

// File: rtl/seq_ctrl_fsm.sv
module seq_ctrl_fsm
    import burst_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  seq_cmd_e   cmd,
    output seq_state_e state,
    output logic       load_en,
    output logic       step_en
);

    seq_state_e state_nxt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Next state and outputs
    always_comb begin
        state_nxt = state;
        load_en   = 1'b0;
        step_en   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                unique case (cmd)
                    CMD_LOAD: begin             // OPEN
                        state_nxt = ST_BURST;
                        load_en   = 1'b1;
                    end
                    CMD_STOP: state_nxt = ST_IDLE; // CLOSE
                    CMD_STEP: state_nxt = ST_IDLE; // IGNORE
                    CMD_HOLD: state_nxt = ST_IDLE; // FREEZE
                endcase
            end
            ST_BURST: begin
                unique case (cmd)
                    CMD_LOAD: begin             // RELOAD
                        state_nxt = ST_BURST;
                        load_en   = 1'b1;
                    end
                    CMD_STOP: state_nxt = ST_IDLE; // CLOSE
                    CMD_STEP: begin             // STEP
                        state_nxt = ST_BURST;
                        step_en   = 1'b1;
                    end
                    CMD_HOLD: state_nxt = ST_BURST; // FREEZE
                endcase
            end
        endcase
    end

    // R8: an advance in idle never opens a burst
    assert_idle_step_stays_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && cmd == CMD_STEP) |=> state == ST_IDLE);

    // R7: a deselect always closes
    assert_stop_closes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_STOP) |=> state == ST_IDLE);

endmodule

// File: rtl/seq_order_step.sv
module seq_order_step #(
    parameter int BEAT_W = 2
) (
    input  logic [BEAT_W-1:0] start_low,
    input  logic [BEAT_W-1:0] beat_idx,
    input  logic              order_ilv,
    output logic [BEAT_W-1:0] low_out
);

    logic [BEAT_W-1:0] lin_low;
    logic [BEAT_W-1:0] ilv_low;

    assign lin_low = start_low + beat_idx;
    assign ilv_low = start_low ^ beat_idx;
    assign low_out = order_ilv ? ilv_low : lin_low;

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int AW        = 18,
    parameter int BURST_LEN = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clk_en,
    input  logic          adv_ld,
    input  logic          chip_sel,
    input  logic [AW-1:0] ext_addr,
    input  logic          order_ilv,
    output logic [AW-1:0] cur_addr,
    output logic          burst_act
);

    localparam int BEAT_W = $clog2(BURST_LEN);

    seq_cmd_e          cmd;
    seq_state_e        state;
    logic              load_en;
    logic              step_en;
    logic [AW-1:0]     addr_q;
    logic [BEAT_W-1:0] start_q;
    logic [BEAT_W-1:0] beat_q;
    logic [BEAT_W-1:0] beat_nxt;
    logic [BEAT_W-1:0] low_nxt;

    seq_cmd_decode u_dec (
        .clk_en   (clk_en),
        .adv_ld   (adv_ld),
        .chip_sel (chip_sel),
        .cmd      (cmd)
    );

    seq_ctrl_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd     (cmd),
        .state   (state),
        .load_en (load_en),
        .step_en (step_en)
    );

    assign beat_nxt = beat_q + BEAT_W'(1);

    seq_order_step #(.BEAT_W(BEAT_W)) u_step (
        .start_low (start_q),
        .beat_idx  (beat_nxt),
        .order_ilv (order_ilv),
        .low_out   (low_nxt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            start_q <= '0;
            beat_q  <= '0;
        end else if (load_en) begin
            addr_q  <= ext_addr;
            start_q <= ext_addr[BEAT_W-1:0];
            beat_q  <= '0;
        end else if (step_en) begin
            addr_q[BEAT_W-1:0] <= low_nxt;
            beat_q             <= beat_nxt;
        end
    end

    assign cur_addr  = addr_q;
    assign burst_act = (state == ST_BURST);

    // R9: a disabled edge changes nothing
    assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> ($stable(cur_addr) && $stable(burst_act)));

    // R2: a load captures the external address and opens a burst
    assert_load_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !adv_ld && chip_sel) |=> (burst_act && cur_addr == $past(ext_addr)));

    // R7: a deselect keeps the address
    assert_stop_keeps_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !adv_ld && !chip_sel) |=> $stable(cur_addr));

    // R8: an advance with no open burst is ignored
    assert_idle_advance_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && adv_ld && !burst_act) |=> ($stable(cur_addr) && !burst_act));

    // R5: the upper bits do not move on a step
    assert_upper_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && adv_ld && burst_act) |=>
            (cur_addr[AW-1:BEAT_W] == $past(cur_addr[AW-1:BEAT_W]) && burst_act));

    // R3: a linear step adds one to the low bits
    assert_linear_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && adv_ld && burst_act && !order_ilv) |=>
            cur_addr[BEAT_W-1:0] == $past(cur_addr[BEAT_W-1:0]) + BEAT_W'(1));

    // R4: an interleaved step always flips at least one low bit
    assert_ilv_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && adv_ld && burst_act && order_ilv) |=>
            $countones(cur_addr[BEAT_W-1:0] ^ $past(cur_addr[BEAT_W-1:0])) != 0);

endmodule

// File: tb/burst_addr_seq_test.sv
module burst_addr_seq_test;

    localparam int  AW       = 18;
    localparam time CLK_PER  = 10ns;
    localparam int  WD_LIMIT = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_en = 1'b0;
    logic          adv_ld = 1'b1;
    logic          chip_sel = 1'b0;
    logic [AW-1:0] ext_addr = '0;
    logic          order_ilv = 1'b0;
    logic [AW-1:0] cur_addr;
    logic          burst_act;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit done     = 1'b0;

    // reference model
    logic [AW-1:0] m_addr  = '0;
    logic          m_act   = 1'b0;
    logic [1:0]    m_start = '0;
    logic [1:0]    m_beat  = '0;

    burst_addr_seq #(.AW(AW), .BURST_LEN(4)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en    (clk_en),
        .adv_ld    (adv_ld),
        .chip_sel  (chip_sel),
        .ext_addr  (ext_addr),
        .order_ilv (order_ilv),
        .cur_addr  (cur_addr),
        .burst_act (burst_act)
    );

    always #(CLK_PER/2) clk = ~clk;

    function automatic logic [1:0] exp_low(input logic [1:0] st, input logic [1:0] k,
                                           input logic ilv);
        return ilv ? (st ^ k) : (st + k);
    endfunction

    task automatic check(input string tag, input logic [AW-1:0] ea, input logic eact);
        n_checks++;
        if (cur_addr !== ea || burst_act !== eact) begin
            n_fail++;
            $display("FAIL %s: addr=%h act=%b expected addr=%h act=%b",
                     tag, cur_addr, burst_act, ea, eact);
        end
    endtask

    // one command: drive at negedge, one rising edge, check at next negedge
    task automatic cycle(input logic ce, input logic adv, input logic sel,
                         input logic [AW-1:0] a);
        string         tag;
        logic [AW-1:0] prev_addr;
        prev_addr = m_addr;
        clk_en = ce; adv_ld = adv; chip_sel = sel; ext_addr = a;
        if (!ce) begin
            tag = "R9";
        end else if (!adv && sel) begin
            tag = m_act ? "R10" : "R2";
            m_addr = a; m_start = a[1:0]; m_beat = '0; m_act = 1'b1;
        end else if (!adv) begin
            tag = "R7";
            m_act = 1'b0;
        end else if (!m_act) begin
            tag = "R8";
        end else begin
            tag = (m_beat == 2'd3) ? "R6" : (order_ilv ? "R4" : "R3");
            m_beat = m_beat + 2'd1;
            m_addr[1:0] = exp_low(m_start, m_beat, order_ilv);
        end
        @(posedge clk);
        @(negedge clk);
        check(tag, m_addr, m_act);
        if (ce && adv && m_act) begin
            n_checks++;
            if (cur_addr[AW-1:2] !== prev_addr[AW-1:2]) begin
                n_fail++;
                $display("FAIL R5: upper=%h expected upper=%h",
                         cur_addr[AW-1:2], prev_addr[AW-1:2]);
            end
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT && !done) begin
            n_fail++;
            $display("FAIL watchdog: cycles=%0d expected below %0d", cyc, WD_LIMIT);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] ra;
        void'($urandom(32'd1234));
        #(CLK_PER*2);
        @(negedge clk);
        check("R1", '0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", '0, 1'b0);

        // R8: advance with no burst open
        cycle(1'b1, 1'b1, 1'b1, 18'h3ffff);
        // R3 linear from start 1: 1,2,3,0 then wrap to 1 (R6)
        order_ilv = 1'b0;
        cycle(1'b1, 1'b0, 1'b1, 18'h2a5a1);
        for (int i = 0; i < 5; i++) cycle(1'b1, 1'b1, 1'b1, 18'h00000);
        n_checks++;
        if (cur_addr[1:0] !== 2'd2) begin
            n_fail++;
            $display("FAIL R6: low=%0d expected low=2", cur_addr[1:0]);
        end
        // R9: disabled edges ignore a load
        cycle(1'b0, 1'b0, 1'b1, 18'h11111);
        cycle(1'b0, 1'b1, 1'b0, 18'h22222);
        // R7: stop holds address
        cycle(1'b1, 1'b0, 1'b0, 18'h33333);
        cycle(1'b1, 1'b1, 1'b1, 18'h33333);
        // R4 interleaved from start 1: 1,0,3,2
        order_ilv = 1'b1;
        cycle(1'b1, 1'b0, 1'b1, 18'h15551);
        cycle(1'b1, 1'b1, 1'b1, 18'h0);
        n_checks++;
        if (cur_addr[1:0] !== 2'd0) begin
            n_fail++;
            $display("FAIL R4: low=%0d expected low=0", cur_addr[1:0]);
        end
        cycle(1'b1, 1'b1, 1'b1, 18'h0);
        cycle(1'b1, 1'b1, 1'b1, 18'h0);
        cycle(1'b1, 1'b1, 1'b1, 18'h0);
        cycle(1'b1, 1'b1, 1'b1, 18'h0);
        // R10: reload mid-burst
        cycle(1'b1, 1'b1, 1'b1, 18'h0);
        cycle(1'b1, 1'b0, 1'b1, 18'h0abc6);
        cycle(1'b1, 1'b1, 1'b1, 18'h0);

        // random phases, one per order, separated by a deselect
        for (int ph = 0; ph < 2; ph++) begin
            cycle(1'b1, 1'b0, 1'b0, '0);
            order_ilv = ph[0];
            for (int i = 0; i < 1500; i++) begin
                ra = AW'($urandom);
                cycle(($urandom % 10) != 0, ($urandom % 10) < 7,
                      ($urandom % 8) != 0, ra);
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule